// File: doc/BRIEF.md
# GPIO Bank with Event Interrupts

A bank of general-purpose pins behind a small 32-bit register bus. Each pin owns one configuration word. That word holds the value driven on the pin's output, a read-only copy of the pin's synchronized input level, an input inversion flag and a two-bit event-mode selector. Inputs pass through a two-flop synchronizer. The event detector then watches the (optionally inverted) level for a level condition, a rising edge or any change.

Detected events set bits in 32-bit status words, one bit per pin. A bit sets whether or not the pin is enabled. Software clears a bit by writing a one to it. A parallel set of enable words gates the status bits into one level-sensitive interrupt line, which stays high until software clears the bits that cause it. The pin count is a parameter (78, 77, 47 or 43). Status and enable bits beyond the last pin do not exist.

Top module: `gpio_evt_bank`

## Requirements
- R1: Pin n's configuration word is at byte address 0x500 + 8*n. Writable fields are bit 0 (output value, driven on `pin_out[n]`), bit 23 (input inversion) and bits 26:25 (event mode). All other bits read 0, and the word at 0x504 + 8*n reads 0.
- R2: Configuration bit 1 reads the pin's input after a two-flop synchronizer. It becomes 1 two clock edges after the input rises, and bus writes to it have no effect.
- R3: The status word for pins 32k..32k+31 is at 0x100 + 4k, with bit b for pin 32k+b. Writing a 1 clears that bit. Writing a 0 leaves it unchanged.
- R4: The enable word for the same pins is at 0x110 + 4k. It is read/write.
- R5: A status bit latches on its pin's event even when the enable bit is 0. `irq` is 1 exactly when some bit is set in both status and enable.
- R6: Mode 00 (level): the status bit is set on every cycle that the synchronized, inverted-if-selected input is 1. It therefore sets again after a clear while that level stays 1.
- R7: Mode 01 (edge): only a 0-to-1 transition of the synchronized, inverted-if-selected input is an event.
- R8: Mode 11 (both edges): any transition of the synchronized, inverted-if-selected input is an event.
- R9: Bit 23 set inverts the input before event detection, so an active-low source acts as active-high.
- R10: Mode 10 generates no events.
- R11: When a clear write and a new event hit the same status bit in the same cycle, the bit ends set.
- R12: Status and enable bits for pin indices at or above the pin count read 0 and cannot be set.
- R13: After reset every configuration word reads 0 (apart from the live input bit). All status and enable words read 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word-aligned byte address |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Output values from configuration bit 0 |
| irq | output | 1 | Combined interrupt, level |

## Verification
The assertions assume that bus addresses are word aligned. They also assume that a write is held for exactly one clock edge, so the clear and set checks can look one cycle back at the write data. The bench drives the bus and the pin inputs only at falling clock edges and reads on a settled, combinational read path. It changes a pin input only after the previous synchronizer activity has settled for at least five cycles, so every event falls in a known cycle relative to a clear write.

// File: rtl/gpio_evt_pkg.sv
// Shared constants and types for the GPIO event bank.
// Assumes byte addressing with 32-bit words.
package gpio_evt_pkg;
    typedef enum logic [1:0] {
        EVT_LEVEL = 2'b00,
        EVT_EDGE  = 2'b01,
        EVT_OFF   = 2'b10,
        EVT_BOTH  = 2'b11
    } evt_mode_e;

    localparam int WORD_W       = 32;
    localparam int CFG_TX_BIT   = 0;
    localparam int CFG_RX_BIT   = 1;
    localparam int CFG_INV_BIT  = 23;
    localparam int CFG_MODE_LSB = 25;
    localparam int STS_BASE     = 'h100;
    localparam int EN_BASE      = 'h110;
    localparam int CFG_BASE     = 'h500;
    localparam int CFG_STRIDE   = 8;
endpackage

// File: rtl/gpio_evt_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherency is provided.
module gpio_evt_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages in series; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_evt_pin.sv
// Per-pin configuration word and event detector.
// Assumes rx_sync is already synchronized to clk. The event output is
// combinational from the registered state and the synchronized input.
module gpio_evt_pin
    import gpio_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              wr_tx,
    input  logic              wr_inv,
    input  logic [1:0]        wr_mode,
    input  logic              rx_sync,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              tx,
    output logic              evt,
    output logic [1:0]        mode_o
);
    logic      inv_q;
    evt_mode_e mode_q;
    logic      lvl;
    logic      prev_q;

    assign lvl    = rx_sync ^ inv_q;
    assign mode_o = mode_q;

    // Configuration fields, loaded on a bus write to this pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx     <= 1'b0;
            inv_q  <= 1'b0;
            mode_q <= EVT_LEVEL;
        end else if (cfg_wr) begin
            tx     <= wr_tx;
            inv_q  <= wr_inv;
            mode_q <= evt_mode_e'(wr_mode);
        end
    end

    // Previous detected level, used for the edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Event selection by mode.
    always_comb begin
        unique case (mode_q)
            EVT_LEVEL: evt = lvl;
            EVT_EDGE:  evt = lvl & ~prev_q;
            EVT_BOTH:  evt = lvl ^ prev_q;
            default:   evt = 1'b0;
        endcase
    end

    // Readback word assembly.
    always_comb begin
        cfg_rdata                                 = '0;
        cfg_rdata[CFG_TX_BIT]                     = tx;
        cfg_rdata[CFG_RX_BIT]                     = rx_sync;
        cfg_rdata[CFG_INV_BIT]                    = inv_q;
        cfg_rdata[CFG_MODE_LSB+1:CFG_MODE_LSB]    = mode_q;
    end
endmodule

// File: rtl/gpio_evt_bank.sv
// GPIO bank: per-pin configuration, write-one-to-clear status words,
// enable words and one combined level interrupt.
// Assumes word-aligned addresses and a combinational read path.
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 78,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                irq
);
    localparam int NUM_GRP = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int PAD_W   = NUM_GRP * WORD_W;
    localparam int PIN_IW  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    // Valid-bit mask of a status or enable group.
    function automatic logic [WORD_W-1:0] grp_mask(input int g);
        logic [WORD_W-1:0] m;
        for (int b = 0; b < WORD_W; b++) m[b] = (g * WORD_W + b) < NUM_PINS;
        return m;
    endfunction

    logic [NUM_PINS-1:0] rx_sync;
    logic [PAD_W-1:0]    evt_flat;
    logic [PAD_W-1:0]    sts_flat;
    logic [PAD_W-1:0]    en_flat;
    logic [WORD_W-1:0]   cfg_rd [NUM_PINS];
    logic [1:0]          mode_all [NUM_PINS];
    logic [1:0]          mode0;
    logic [ADDR_W-1:0]   cfg_off;
    logic [ADDR_W-1:0]   cfg_idx;
    logic                cfg_hit;

    gpio_evt_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (rx_sync)
    );

    // Configuration-region decode.
    assign cfg_off = bus_addr - ADDR_W'(CFG_BASE);
    assign cfg_idx = cfg_off >> 3;
    assign cfg_hit = (bus_addr >= ADDR_W'(CFG_BASE)) && (cfg_off[2:0] == 3'b000)
                     && (cfg_idx < ADDR_W'(NUM_PINS));
    assign mode0   = mode_all[0];

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic pin_wr;
            assign pin_wr = bus_wr && cfg_hit && (cfg_idx == ADDR_W'(p));
            gpio_evt_pin u_pin (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg_wr    (pin_wr),
                .wr_tx     (bus_wdata[CFG_TX_BIT]),
                .wr_inv    (bus_wdata[CFG_INV_BIT]),
                .wr_mode   (bus_wdata[CFG_MODE_LSB+1:CFG_MODE_LSB]),
                .rx_sync   (rx_sync[p]),
                .cfg_rdata (cfg_rd[p]),
                .tx        (pin_out[p]),
                .evt       (evt_flat[p]),
                .mode_o    (mode_all[p])
            );
        end
        if (PAD_W > NUM_PINS) begin : g_pad
            assign evt_flat[PAD_W-1:NUM_PINS] = '0;
        end

        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            localparam logic [WORD_W-1:0] VMASK = grp_mask(g);
            logic              sts_wr, en_wr;
            logic [WORD_W-1:0] sts_q, en_q;
            assign sts_wr = bus_wr && (bus_addr == ADDR_W'(STS_BASE + 4 * g));
            assign en_wr  = bus_wr && (bus_addr == ADDR_W'(EN_BASE + 4 * g));

            // Status: write-one clear, then new events set (set wins).
            always_ff @(posedge clk) begin
                if (!rst_n) sts_q <= '0;
                else sts_q <= ((sts_q & ~(sts_wr ? bus_wdata : '0))
                               | evt_flat[g*WORD_W +: WORD_W]) & VMASK;
            end

            // Enable: plain read/write mask limited to existing pins.
            always_ff @(posedge clk) begin
                if (!rst_n)     en_q <= '0;
                else if (en_wr) en_q <= bus_wdata & VMASK;
            end

            assign sts_flat[g*WORD_W +: WORD_W] = sts_q;
            assign en_flat[g*WORD_W +: WORD_W]  = en_q;
        end
    endgenerate

    // Combined interrupt line.
    assign irq = |(sts_flat & en_flat);

    // Read multiplexer over status, enable and configuration words.
    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (bus_addr == ADDR_W'(STS_BASE + 4 * g)) bus_rdata = sts_flat[g*WORD_W +: WORD_W];
            if (bus_addr == ADDR_W'(EN_BASE + 4 * g))  bus_rdata = en_flat[g*WORD_W +: WORD_W];
        end
        if (cfg_hit) bus_rdata = cfg_rd[cfg_idx[PIN_IW-1:0]];
    end
endmodule

// File: rtl/gpio_evt_bank_chk.sv
// Property checker for gpio_evt_bank, attached by bind.
// Assumes word-aligned bus addresses and single-cycle write strobes.
module gpio_evt_bank_chk #(
    parameter int NUM_PINS = 78,
    parameter int ADDR_W   = 12,
    parameter int PAD_W    = 96
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [31:0]         bus_wdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [PAD_W-1:0]    evt_flat,
    input logic [PAD_W-1:0]    sts_flat,
    input logic [PAD_W-1:0]    en_flat,
    input logic [1:0]          mode0
);
    localparam logic [ADDR_W-1:0] STS0 = ADDR_W'('h100);
    localparam logic [ADDR_W-1:0] CFG0 = ADDR_W'('h500);

    logic [PAD_W-1:0] pad_mask;
    always_comb begin
        for (int i = 0; i < PAD_W; i++) pad_mask[i] = (i >= NUM_PINS);
    end

    // R11
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flat[0] |=> sts_flat[0]);

    // R3
    sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STS0 && bus_wdata[0] && !evt_flat[0]) |=> !sts_flat[0]);

    // R3
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_flat[0] && !(bus_wr && bus_addr == STS0 && bus_wdata[0])) |=> sts_flat[0]);

    // R10
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 2'b10 && !sts_flat[0]) |=> !sts_flat[0]);

    // R1
    tx_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CFG0) |=> (pin_out[0] == $past(bus_wdata[0])));

    // R12
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_flat & pad_mask) == '0) && ((en_flat & pad_mask) == '0));
endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .PAD_W    (PAD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .evt_flat  (evt_flat),
    .sts_flat  (sts_flat),
    .en_flat   (en_flat),
    .mode0     (mode0)
);

// File: tb/gpio_evt_bank_tb.sv
// Self-checking bench: a vector table for event modes, then directed tests.
module gpio_evt_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 78;
    localparam int AW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in = '0;
    logic [NP-1:0]   pin_out;
    logic            irq;
    int              total = 0;
    int              bad = 0;
    bit              done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_evt_bank #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .irq(irq)
    );

    // Vector: mode[5:4], inv[3], input before[2], input after[1], expected status[0]
    localparam logic [5:0] VEC [14] = '{
        6'b00_0_0_1_1, 6'b00_0_0_0_0, 6'b00_1_1_1_0, 6'b00_1_1_0_1,
        6'b01_0_0_1_1, 6'b01_0_1_0_0, 6'b01_1_1_0_1, 6'b01_1_0_1_0,
        6'b11_0_0_1_1, 6'b11_0_1_0_1, 6'b11_1_1_0_1, 6'b11_0_1_1_0,
        6'b10_0_0_1_0, 6'b10_1_1_0_0
    };

    function automatic logic [AW-1:0] cfg_a(input int p);
        return AW'('h500 + 8 * p);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R13 reset state
        bus_read(AW'('h100), rd); check("R13 sts0", rd, 0);
        bus_read(AW'('h108), rd); check("R13 sts2", rd, 0);
        bus_read(AW'('h114), rd); check("R13 en1", rd, 0);
        bus_read(cfg_a(0), rd);   check("R13 cfg0", rd, 0);
        check("R13 irq", {31'b0, irq}, 0);

        // R1 writable fields, output drive, unused word
        bus_write(cfg_a(3), 32'hFFFF_FFFF);
        bus_read(cfg_a(3), rd);   check("R1 cfg3 readback", rd, 32'h0680_0001);
        check("R1 pin_out3", {31'b0, pin_out[3]}, 1);
        bus_read(cfg_a(3) + AW'(4), rd); check("R1 second word", rd, 0);
        bus_write(cfg_a(3), 32'h0000_0000);
        check("R1 pin_out3 low", {31'b0, pin_out[3]}, 0);

        // R2 synchronized input readback, read-only
        @(negedge clk); pin_in[7] = 1'b1;
        bus_read(cfg_a(7), rd);   check("R2 rx after one edge", rd, 0);
        bus_read(cfg_a(7), rd);   check("R2 rx after two edges", rd, 32'h2);
        bus_write(cfg_a(7), 32'h0000_0002);
        bus_read(cfg_a(7), rd);   check("R2 rx still input", rd, 32'h2);
        pin_in[7] = 1'b0;
        bus_write(cfg_a(7), 32'h0400_0000);  // mode 10, stop events

        // R6 R7 R8 R9 R10 R5 vector table on pin 5, enables all 0
        for (int i = 0; i < 14; i++) begin
            logic [5:0] v;
            v = VEC[i];
            @(negedge clk); pin_in[5] = v[2];
            bus_write(cfg_a(5), (32'(v[5:4]) << 25) | (32'(v[3]) << 23));
            idle(5);
            bus_write(AW'('h100), 32'hFFFF_FFFF);
            pin_in[5] = v[1];
            idle(5);
            bus_read(AW'('h100), rd);
            check($sformatf("R6/R7/R8/R9/R10 vector %0d", i), {31'b0, rd[5]}, {31'b0, v[0]});
            check("R5 no irq while disabled", {31'b0, irq}, 0);
        end
        @(negedge clk); pin_in[5] = 1'b0;
        bus_write(cfg_a(5), 32'h0400_0000);

        // R5 R4 R11 R3 on pin 40 (group 1 bit 8), level mode
        @(negedge clk); pin_in[40] = 1'b1;
        idle(5);
        bus_read(AW'('h104), rd); check("R5 latch disabled", rd, 32'h100);
        check("R5 irq low", {31'b0, irq}, 0);
        bus_write(AW'('h114), 32'hFFFF_FFFF);
        bus_read(AW'('h114), rd); check("R4 en1 readback", rd, 32'hFFFF_FFFF);
        check("R5 irq high", {31'b0, irq}, 1);
        bus_write(AW'('h104), 32'hFFFF_FFFF);
        bus_read(AW'('h104), rd); check("R11 set wins", rd, 32'h100);
        bus_write(AW'('h104), 32'h0);
        bus_read(AW'('h104), rd); check("R3 zero write keeps", rd, 32'h100);
        @(negedge clk); pin_in[40] = 1'b0;
        idle(5);
        bus_write(AW'('h104), 32'h0000_0100);
        bus_read(AW'('h104), rd); check("R3 cleared", rd, 0);
        check("R5 irq after clear", {31'b0, irq}, 0);
        bus_write(AW'('h114), 32'h0);
        bus_read(AW'('h114), rd); check("R4 en1 cleared", rd, 0);

        // R12 partial top group
        bus_write(AW'('h118), 32'hFFFF_FFFF);
        bus_read(AW'('h118), rd); check("R12 en2 mask", rd, 32'h0000_3FFF);
        @(negedge clk); pin_in[77:64] = '1;
        idle(5);
        bus_read(AW'('h108), rd); check("R12 sts2 mask", rd, 32'h0000_3FFF);
        check("R5 irq group2", {31'b0, irq}, 1);
        @(negedge clk); pin_in[77:64] = '0;
        idle(5);
        bus_write(AW'('h108), 32'hFFFF_FFFF);
        bus_read(AW'('h108), rd); check("R12 sts2 cleared", rd, 0);
        check("R5 irq gone", {31'b0, irq}, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule